// File: doc/BRIEF.md
# Serial Status/Command Register Port for a Switch Monitor

This block is the serial slave port of a switch-monitor device. A host selects it with an active-low chip select and clocks 16 bits through it. During that frame the port sends out a 16-bit status word captured at the moment of selection. At the same time it gathers a 16-bit command word from the data-in line. When the host deselects the port, the gathered word becomes the new command word, but only if exactly 16 bits were clocked. Any other bit count leaves the command unchanged.

The port also produces a one-cycle clear pulse each time chip select falls. Neighbouring logic uses this pulse to release the interrupt and overtemperature output flags. The port keeps the overtemperature status bit itself. Two digital comparator flags drive that bit: a "hot" flag (above the warning threshold) and a "cool" flag (below the lower release threshold). Together they give the bit its hysteresis.

All serial pins and both comparator flags are asynchronous to the system clock. They pass through a parameterised synchronizer chain, and every serial event is detected as an edge inside the system-clock domain. The switch status input is taken as quasi-static. It is sampled directly when chip select falls.

Top module: `swmon_spi_port`

## Requirements
- R1: After reset, the command word is 0x0000, the overtemperature bit is 0, and the data-out enable is low.
- R2: On each chip-select falling edge, a status word is captured. Its layout is: bit 15 down to bit 8 hold switch status bits 7 down to 0, bit 7 holds the overtemperature bit at that moment, and bits 6 to 0 read 0.
- R3: The status word is sent MSB first. Bit 15 appears on data out when chip select falls. Each following bit appears after the next rising clock edge.
- R4: Data in is sampled on falling clock edges, MSB first. If exactly 16 falling edges occurred while selected, the sampled word becomes the command word when chip select rises. The word is committed bit for bit, so every command field keeps its position.
- R5: If chip select rises after any number of falling clock edges other than 16 (including fewer, more, or none), the command word is unchanged.
- R6: While chip select is high, the data-out enable is low, and clock and data-in activity changes neither the data-out value nor the command word.
- R7: Every chip-select falling edge produces a clear pulse exactly one system clock wide. The pulse does not depend on the overtemperature bit or on the switch status.
- R8: The overtemperature bit is set while the hot flag is high. It is cleared when the cool flag is high and the hot flag is low. It holds its value when neither flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Data-out driver enable (high-impedance when low) |
| sw_status | input | 8 | Debounced switch states, 1 = closed |
| temp_hot | input | 1 | Comparator flag: temperature above warning threshold |
| temp_cool | input | 1 | Comparator flag: temperature below release threshold |
| alert_clr | output | 1 | One-cycle clear pulse for the interrupt and overtemperature output flags |
| ot_status | output | 1 | Overtemperature status bit |
| cmd_word | output | 16 | Committed command word |

## Verification
The bench builds the port with a word width of 16, eight switch bits and a synchronizer depth of 3. This is one stage deeper than the default, so the generate chain and the added latency from serial pin to internal edge are exercised. Frames of 8, 15, 16 and 17 clocks are sent with random data. This covers the commit rule on both sides of the exact count and the saturation of the bit counter. Comparator flag changes between frames check that the overtemperature bit sets, holds and releases, and that the status word captures it when chip select falls.

// File: rtl/swmon_pkg.sv
package swmon_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_SW_W   = 8;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/swmon_sync.sv
module swmon_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= RST;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/swmon_ot.sv
module swmon_ot (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cool,
  output logic ot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot <= 1'b0;
    else if (hot) ot <= 1'b1;
    else if (cool) ot <= 1'b0;
  end

  AST_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> ot); // R8
  AST_OT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cool && !hot) |=> !ot); // R8
  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cool && !hot) |=> $stable(ot)); // R8
endmodule

// File: rtl/swmon_shift.sv
module swmon_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic [WORD_W-1:0] load_word,
  output logic              dout,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full
);
  localparam int unsigned   CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sh   <= load_word;
      cnt  <= '0;
      dout <= load_word[WORD_W-1];
    end else if (active) begin
      if (sclk_fall) begin
        sh  <= {sh[WORD_W-2:0], din};
        cnt <= sat_inc(cnt);
      end
      if (sclk_rise) dout <= sh[WORD_W-1];
    end
  end

  assign rx_word = sh;
  assign rx_full = (cnt == CNT_FULL);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX); // R5
endmodule

// File: rtl/swmon_spi_port.sv
module swmon_spi_port #(
  parameter int unsigned WORD_W      = swmon_pkg::DEF_WORD_W,
  parameter int unsigned SW_W        = swmon_pkg::DEF_SW_W,
  parameter int unsigned SYNC_STAGES = swmon_pkg::DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [SW_W-1:0]   sw_status,
  input  logic              temp_hot,
  input  logic              temp_cool,
  output logic              alert_clr,
  output logic              ot_status,
  output logic [WORD_W-1:0] cmd_word
);
  localparam int unsigned PAD_W = WORD_W - SW_W - 1;

  function automatic logic [WORD_W-1:0] build_status(
    input logic [SW_W-1:0] sw, input logic ot);
    return {sw, ot, {PAD_W{1'b0}}};
  endfunction

  logic [4:0] pins_s;
  logic cs_s, sclk_s, mosi_s, hot_s, cool_s;
  logic cs_d, sclk_d;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [WORD_W-1:0] status_w, rx_word, cmd_q;
  logic rx_full, dout;

  swmon_sync #(.W(5), .STAGES(SYNC_STAGES), .RST(5'b10000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, mosi, temp_hot, temp_cool}), .q(pins_s));

  assign {cs_s, sclk_s, mosi_s, hot_s, cool_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  swmon_ot u_ot (.clk(clk), .rst_n(rst_n), .hot(hot_s), .cool(cool_s), .ot(ot_status));

  assign status_w = build_status(sw_status, ot_status);

  swmon_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(cs_fall), .active(~cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(mosi_s),
    .load_word(status_w), .dout(dout), .rx_word(rx_word), .rx_full(rx_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cs_rise && rx_full) cmd_q <= rx_word;
  end

  assign cmd_word  = cmd_q;
  assign miso      = dout;
  assign miso_oe   = ~cs_s;
  assign alert_clr = cs_fall;

  AST_STATUS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (miso == $past(sw_status[SW_W-1]))); // R2 R3
  AST_CMD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !rx_full) |=> $stable(cmd_word)); // R5
  AST_CMD_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cmd_word)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |=> $stable(miso)); // R6
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |=> !alert_clr); // R7
endmodule

// File: tb/sim_swmon_spi_port.sv
module sim_swmon_spi_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, alert_clr, ot_status;
  logic [7:0] sw_status = '0;
  logic temp_hot = 1'b0, temp_cool = 1'b0;
  logic [15:0] cmd_word;

  int chk = 0, err = 0, clr_cnt = 0;
  logic [15:0] cmd_exp = 16'h0000;
  logic ot_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swmon_spi_port #(.WORD_W(16), .SW_W(8), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .sw_status(sw_status),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .alert_clr(alert_clr),
    .ot_status(ot_status), .cmd_word(cmd_word));

  always @(posedge clk) if (rst_n && alert_clr) clr_cnt++;

  function automatic logic [15:0] exp_status(input logic [7:0] sw, input logic ot);
    logic [15:0] s;
    s = 16'h0000;
    for (int i = 0; i < 8; i++) s[8+i] = sw[i];
    s[7] = ot;
    return s;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    chk++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] dat, input int len, output logic [15:0] rx);
    rx = 16'h0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < len; i++) begin
      mosi = (i < 16) ? dat[15-i] : 1'b0;
      sclk = 1'b1;
      wait_clk(HALF);
      if (i < 16) rx[15-i] = miso;
      sclk = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic set_temp(input logic h, input logic c);
    temp_hot = h; temp_cool = c;
    if (h) ot_exp = 1'b1; else if (c) ot_exp = 1'b0;
    wait_clk(8);
  endtask

  task automatic run_frame(input logic [15:0] dat, input int len, input string tag);
    logic [15:0] rx, mask, se;
    int c0;
    c0 = clr_cnt;
    se = exp_status(sw_status, ot_exp);
    frame(dat, len, rx);
    mask = (len >= 16) ? 16'hFFFF : ~(16'hFFFF >> len);
    if (len == 16) cmd_exp = dat;
    check(rx & mask, se & mask, {tag, " R2 R3 status"});
    check(cmd_word, cmd_exp, (len == 16) ? {tag, " R4 commit"} : {tag, " R5 no commit"});
    check(16'(clr_cnt - c0), 16'd1, {tag, " R7 clear pulse"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  end

  initial begin
    int lens[6] = '{16, 16, 16, 15, 17, 8};
    void'($urandom(32'd1234));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    check(cmd_word, 16'h0000, "R1 reset cmd");
    check({15'd0, ot_status}, 16'd0, "R1 reset ot");
    check({15'd0, miso_oe}, 16'd0, "R1 reset oe");

    sw_status = 8'hA5;
    run_frame(16'hC3A1, 16, "dir1");
    sw_status = 8'h01;
    run_frame(16'h8001, 16, "dir2");
    run_frame(16'hFFFF, 15, "short15");
    run_frame(16'h1234, 17, "long17");
    run_frame(16'h5555, 0, "empty");

    // R6: idle bus activity ignored
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk; mosi = $urandom_range(0, 1);
      wait_clk(HALF);
      check({15'd0, miso_oe}, 16'd0, "R6 oe low idle");
    end
    sclk = 1'b0;
    wait_clk(HALF);
    check(cmd_word, cmd_exp, "R6 idle no commit");

    // R8 hysteresis, R2/R7 with ot set
    set_temp(1, 0);
    check({15'd0, ot_status}, {15'd0, ot_exp}, "R8 set");
    set_temp(0, 0);
    check({15'd0, ot_status}, {15'd0, ot_exp}, "R8 hold high");
    sw_status = 8'h3C;
    run_frame(16'h0F0F, 16, "ot_frame");
    check({15'd0, ot_status}, 16'd1, "R7 R8 ot stays after clear");
    set_temp(0, 1);
    check({15'd0, ot_status}, {15'd0, ot_exp}, "R8 release");
    set_temp(1, 1);
    check({15'd0, ot_status}, {15'd0, ot_exp}, "R8 hot wins");
    set_temp(0, 0);

    for (int n = 0; n < 40; n++) begin
      logic [15:0] d;
      int l;
      d = 16'($urandom);
      l = lens[$urandom_range(0, 5)];
      sw_status = 8'($urandom);
      if ($urandom_range(0, 3) == 0)
        set_temp(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check({15'd0, ot_status}, {15'd0, ot_exp}, "R8 random");
      run_frame(d, l, "rand");
    end

    $display("CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  end
endmodule